// File: doc/BRIEF.md
# Ternary Multi-Digit Ripple Adder

The block adds two unsigned base-3 numbers of three digits each, together with a carry-in of zero or one. Each digit (trit) travels on a two-bit binary code. A chain of identical full-adder cells produces the result. Each cell forms the modulo-3 sum of its two operand digits and its incoming carry, and passes a carry of one to the next cell up when that total reaches three. The carry out of the top cell becomes the block's carry-out.

The result is captured in an output register one clock after the operands are presented. A digit code outside the legal set makes the block raise an error flag for that result instead of an arithmetic value. A carry-in that is not zero or one has the same effect. The addition is symmetric, so the two operand ports can be swapped freely.

Top module: `tern_ripple_adder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are `sum_o` = 0, `cout_o` = 0 and `err_o` = 0, whatever the inputs are.
- R2: Digit k of an operand or of the sum sits at bits [2k+1:2k]. Digit 0 is least significant. Value 0 is coded 2'b00, value 1 is 2'b01 and value 2 is 2'b10. Each legal sum digit equals (a_k + b_k + carry_k) mod 3, where carry_0 is the carry-in.
- R3: For legal inputs, the integer value of `a_i` + `b_i` + `cin_i` equals 27·`cout_o` + the value of `sum_o`. The carry ripples from digit 0 up to digit 2 and then out. `cout_o` uses the same code and is only ever 2'b00 or 2'b01.
- R4: A result appears on the outputs at the first rising edge after the inputs are applied. Before that edge the outputs hold their previous value.
- R5: If any operand digit carries the code 2'b11, then at the next edge `err_o` = 1, `sum_o` = 0 and `cout_o` = 0.
- R6: A carry-in code of 2'b10 or 2'b11 is illegal. It produces the same result as R5.
- R7: Swapping the `a_i` and `b_i` values leaves `sum_o` and `cout_o` unchanged.
- R8: Whenever `err_o` is 0, no sum digit is 2'b11 and `cout_o` is 2'b00 or 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| a_i | input | 6 | First operand, three trit codes |
| b_i | input | 6 | Second operand, three trit codes |
| cin_i | input | 2 | Carry-in trit code, legal values 0 and 1 |
| sum_o | output | 6 | Registered sum, three trit codes |
| cout_o | output | 2 | Registered carry-out trit code |
| err_o | output | 1 | Registered flag for an illegal input code |

## Verification
Two things can land in one cycle: a carry that ripples through every digit and an illegal code that must override the arithmetic. The bench provokes this by applying the largest operands together with a carry-in code of 2'b10. It also applies a code of 2'b11 in a middle digit while the other digits would generate carries. In both cases it expects the error flag with zeroed sum and carry-out, not the wrapped value. Every legal combination of operands and carry-in is also applied, and the bench checks the integer identity of R3 for each one.

// File: rtl/tern_pkg.sv
// Package tern_pkg: shared trit type and code constants for the ternary adder.
// Assumes a trit is held in two bits, with the value equal to the binary code.
package tern_pkg;
    localparam int TRIT_W = 2;
    typedef logic [TRIT_W-1:0] trit_t;
    localparam trit_t TRIT_ZERO = 2'b00;
    localparam trit_t TRIT_ONE  = 2'b01;
    localparam trit_t TRIT_TWO  = 2'b10;
    localparam trit_t TRIT_BAD  = 2'b11;
endpackage

// File: rtl/tern_fa_cell.sv
// Module tern_fa_cell: one ternary full-adder digit, purely combinational.
// Assumes legal trit codes on a_i and b_i and a carry of 0 or 1.
// Returns the mod-3 digit sum and a carry that is set when the total reaches 3.
module tern_fa_cell
    import tern_pkg::*;
(
    input  trit_t a_i,
    input  trit_t b_i,
    input  logic  c_i,
    output trit_t s_o,
    output logic  c_o
);
    logic [2:0] total;
    logic [2:0] wrapped;

    // Form the digit total (at most 5) and fold it back into 0..2.
    always_comb begin
        total   = {1'b0, a_i} + {1'b0, b_i} + {2'b00, c_i};
        wrapped = total - 3'd3;
        if (total >= 3'd3) begin
            s_o = wrapped[TRIT_W-1:0];
            c_o = 1'b1;
        end else begin
            s_o = total[TRIT_W-1:0];
            c_o = 1'b0;
        end
    end
endmodule

// File: rtl/tern_code_check.sv
// Module tern_code_check: flags any illegal trit code on the adder inputs.
// Operand digits must not be 2'b11. The carry-in must be 2'b00 or 2'b01.
module tern_code_check
    import tern_pkg::*;
#(
    parameter int NTRIT = 3,
    localparam int OPW  = NTRIT * TRIT_W
) (
    input  logic [OPW-1:0]    a_i,
    input  logic [OPW-1:0]    b_i,
    input  trit_t             cin_i,
    output logic              bad_o
);
    logic [NTRIT-1:0] dig_bad;

    // One flag per digit position, set for a 2'b11 code on either operand.
    for (genvar k = 0; k < NTRIT; k++) begin : g_dig
        assign dig_bad[k] = (a_i[k*TRIT_W +: TRIT_W] == TRIT_BAD) ||
                            (b_i[k*TRIT_W +: TRIT_W] == TRIT_BAD);
    end

    // Combine the digit flags with the carry-in legality test.
    always_comb begin
        bad_o = (|dig_bad) || (cin_i[1] == 1'b1);
    end
endmodule

// File: rtl/tern_ripple_adder.sv
// Module tern_ripple_adder: NTRIT-digit ternary ripple-carry adder with a
// registered result. Assumes a synchronous active-low reset.
// An illegal input code gives an error flag with zero sum and carry-out.
module tern_ripple_adder
    import tern_pkg::*;
#(
    parameter int NTRIT = 3,
    localparam int OPW  = NTRIT * TRIT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] a_i,
    input  logic [OPW-1:0] b_i,
    input  logic [1:0]     cin_i,
    output logic [OPW-1:0] sum_o,
    output logic [1:0]     cout_o,
    output logic           err_o
);
    logic [NTRIT:0]   carry;
    logic [OPW-1:0]   sum_c;
    logic             in_bad;

    assign carry[0] = cin_i[0];

    // Carry chain: digit k feeds its carry into digit k+1.
    for (genvar k = 0; k < NTRIT; k++) begin : g_cell
        tern_fa_cell i_cell (
            .a_i (a_i[k*TRIT_W +: TRIT_W]),
            .b_i (b_i[k*TRIT_W +: TRIT_W]),
            .c_i (carry[k]),
            .s_o (sum_c[k*TRIT_W +: TRIT_W]),
            .c_o (carry[k+1])
        );
    end

    tern_code_check #(.NTRIT(NTRIT)) i_check (
        .a_i   (a_i),
        .b_i   (b_i),
        .cin_i (cin_i),
        .bad_o (in_bad)
    );

    // Result register: reset, error override, or the arithmetic result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_o  <= '0;
            cout_o <= TRIT_ZERO;
            err_o  <= 1'b0;
        end else if (in_bad) begin
            sum_o  <= '0;
            cout_o <= TRIT_ZERO;
            err_o  <= 1'b1;
        end else begin
            sum_o  <= sum_c;
            cout_o <= {1'b0, carry[NTRIT]};
            err_o  <= 1'b0;
        end
    end
endmodule

// File: rtl/tern_adder_chk.sv
// Module tern_adder_chk: temporal checks on tern_ripple_adder, bound to it below.
// Assumes the default trit coding of tern_pkg.
module tern_adder_chk
    import tern_pkg::*;
#(
    parameter int NTRIT = 3,
    localparam int OPW  = NTRIT * TRIT_W
) (
    input logic           clk,
    input logic           rst_n,
    input logic [OPW-1:0] a_i,
    input logic [OPW-1:0] b_i,
    input logic [1:0]     cin_i,
    input logic [OPW-1:0] sum_o,
    input logic [1:0]     cout_o,
    input logic           err_o
);
    function automatic int pow3(input int n);
        int r = 1;
        for (int i = 0; i < n; i++) r = r * 3;
        return r;
    endfunction

    function automatic int tval(input logic [OPW-1:0] x);
        int acc = 0;
        for (int i = NTRIT - 1; i >= 0; i--) acc = acc * 3 + int'(x[i*TRIT_W +: TRIT_W]);
        return acc;
    endfunction

    function automatic logic has_bad(input logic [OPW-1:0] x);
        logic f = 1'b0;
        for (int i = 0; i < NTRIT; i++) f = f | (x[i*TRIT_W +: TRIT_W] == TRIT_BAD);
        return f;
    endfunction

    localparam int TOP = pow3(NTRIT);

    int   val_in;
    int   val_out;
    logic in_legal;
    logic op_bad;

    // Integer view of inputs and outputs, plus input legality.
    always_comb begin
        val_in   = tval(a_i) + tval(b_i) + int'(cin_i);
        val_out  = tval(sum_o) + TOP * int'(cout_o);
        op_bad   = has_bad(a_i) || has_bad(b_i);
        in_legal = !op_bad && (cin_i[1] == 1'b0);
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (sum_o == '0 && cout_o == 2'b00 && !err_o));

    p_value_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_legal |=> (!err_o && val_out == $past(val_in)));

    p_bad_digit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_bad |=> (err_o && sum_o == '0 && cout_o == 2'b00));

    p_bad_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cin_i[1] |=> (err_o && sum_o == '0 && cout_o == 2'b00));

    p_legal_codes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !err_o |-> (!has_bad(sum_o) && cout_o[1] == 1'b0));
endmodule

bind tern_ripple_adder tern_adder_chk #(.NTRIT(NTRIT)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .sum_o  (sum_o),
    .cout_o (cout_o),
    .err_o  (err_o)
);

// File: tb/test_tern_ripple_adder.sv
// Bench for tern_ripple_adder: vector table, exhaustive sweep, directed cases.
module test_tern_ripple_adder;
    localparam int N = 3;
    localparam int W = 2 * N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [1:0]   cin = 2'b00;
    logic [W-1:0] sum;
    logic [1:0]   cout;
    logic         err;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tern_ripple_adder #(.NTRIT(N)) i_tern_ripple_adder (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .cin_i(cin),
        .sum_o(sum), .cout_o(cout), .err_o(err)
    );

    // Table entry: {a, b, cin, expected sum, expected cout, expected err}
    localparam int NV = 8;
    localparam logic [22:0] VEC [NV] = '{
        {6'b000000, 6'b000000, 2'b00, 6'b000000, 2'b00, 1'b0},
        {6'b101010, 6'b000000, 2'b01, 6'b000000, 2'b01, 1'b0},
        {6'b010101, 6'b010101, 2'b00, 6'b101010, 2'b00, 1'b0},
        {6'b101010, 6'b101010, 2'b01, 6'b101010, 2'b01, 1'b0},
        {6'b000110, 6'b001001, 2'b00, 6'b010100, 2'b00, 1'b0},
        {6'b001100, 6'b000000, 2'b00, 6'b000000, 2'b00, 1'b1},
        {6'b000101, 6'b010000, 2'b10, 6'b000000, 2'b00, 1'b1},
        {6'b100000, 6'b010000, 2'b00, 6'b000000, 2'b01, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] enc(input int v);
        logic [W-1:0] r;
        int t = v;
        for (int i = 0; i < N; i++) begin
            r[2*i +: 2] = 2'(t % 3);
            t = t / 3;
        end
        return r;
    endfunction

    // Drive at a falling edge, sample at the next falling edge.
    task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb, input logic [1:0] tc);
        @(negedge clk);
        a = ta; b = tb; cin = tc;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] s_keep;
        logic [1:0]   c_keep;
        // R1: reset clears outputs even with active inputs.
        a = 6'b101010; b = 6'b101010; cin = 2'b01;
        repeat (3) @(negedge clk);
        check(sum == '0 && cout == 2'b00 && err == 1'b0, "R1 reset state", int'(sum), 0);
        rst_n = 1'b1;

        // Table walk: R2, R3, R5, R6.
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][22:17], VEC[i][16:11], VEC[i][10:9]);
            check(sum == VEC[i][8:3], "R2 table sum", int'(sum), int'(VEC[i][8:3]));
            check(cout == VEC[i][2:1], "R3 table cout", int'(cout), int'(VEC[i][2:1]));
            check(err == VEC[i][0], "R5/R6 table err", int'(err), int'(VEC[i][0]));
        end

        // Exhaustive legal sweep: R3 identity.
        for (int va = 0; va < 27; va++) begin
            for (int vb = 0; vb < 27; vb++) begin
                for (int vc = 0; vc < 2; vc++) begin
                    int tot;
                    apply(enc(va), enc(vb), 2'(vc));
                    tot = va + vb + vc;
                    check(sum == enc(tot % 27) && cout == 2'(tot / 27) && !err,
                          "R3 sweep", int'(sum) + 64 * int'(cout), int'(enc(tot % 27)) + 64 * (tot / 27));
                end
            end
        end

        // R4: output holds until the next rising edge.
        apply(enc(1), enc(1), 2'b00);
        @(negedge clk);
        a = enc(4); b = enc(5); cin = 2'b01;
        #1;
        check(sum == enc(2), "R4 held before edge", int'(sum), int'(enc(2)));
        @(negedge clk);
        check(sum == enc(10), "R4 after edge", int'(sum), int'(enc(10)));

        // R5 with a carry storm: bad middle digit among 2s.
        apply(6'b101110, 6'b101010, 2'b01);
        check(err && sum == '0 && cout == 2'b00, "R5 bad digit over carries", int'(err), 1);
        // R6 with largest operands.
        apply(6'b101010, 6'b101010, 2'b10);
        check(err && sum == '0 && cout == 2'b00, "R6 cin code 10", int'(err), 1);
        apply(enc(3), enc(3), 2'b11);
        check(err && sum == '0, "R6 cin code 11", int'(err), 1);
        // Recovery after error.
        apply(enc(3), enc(3), 2'b00);
        check(!err && sum == enc(6), "R5 recovery", int'(sum), int'(enc(6)));

        // R7: swapping operands.
        apply(enc(17), enc(22), 2'b01);
        s_keep = sum; c_keep = cout;
        apply(enc(22), enc(17), 2'b01);
        check(sum == s_keep && cout == c_keep, "R7 swap", int'(sum), int'(s_keep));

        // R8: cout code range on max carry.
        apply(enc(26), enc(26), 2'b01);
        check(cout == 2'b01 && sum == enc(26), "R8 cout code", int'(cout), 1);

        // R1 again: reset mid-run.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(sum == '0 && cout == 2'b00 && !err, "R1 mid-run reset", int'(sum), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule